// File: doc/BRIEF.md
# Reconfigurable Iterative CORDIC Engine

This block computes plane rotations and vector-to-polar conversions on the circular or the hyperbolic trajectory. It uses one microrotation stage that is reused once per clock cycle instead of an unrolled pipeline. Two control bits pick the operation. `traj_i` = 1 selects circular and 0 selects hyperbolic. `mode_i` = 0 selects rotation (the angle is driven to zero) and 1 selects vectoring (y is driven to zero and the angle is accumulated). The CORDIC gain is not compensated, so the caller scales the results by the gain constant given below.

In circular rotation, the input angle covers a full turn. A preprocessing step reduces it to an angle in [0, π/4] plus an octant code. For odd octants this step reflects the input vector. After the last iteration, a correction step undoes the reflection and applies the quarter-turn rotation that the octant implies. Angles use 16-bit binary units, where 8192 stands for π/4. x and y are 16-bit two's complement. Inside the block they are widened with two integer guard bits and three fraction bits. The `BASIC_SHIFT` parameter (2 or 3) sets the iteration count and the vectoring rollover count.

Top module: `cordic_engine`

## Requirements
- R1: While reset is asserted and after it is released, ready_o=1, done_o=0, and x_o, y_o and z_o are all 0.
- R2: start_i is taken only on a rising edge where ready_o=1. ready_o goes low on the next cycle and stays low until done_o. A start_i pulse, or any change of the data inputs, while ready_o=0 changes neither the result nor its timing.
- R3: Circular rotation (traj_i=1, mode_i=0) treats z_i as an angle θ = z_i·π/32768 that wraps over a full turn. It returns x_o ≈ K(x·cosθ − y·sinθ) and y_o ≈ K(x·sinθ + y·cosθ), where K = ∏ sqrt(1+2^-2k) for k = 0..N−1. The error bound is 72 LSB for BASIC_SHIFT=2 and 24 LSB for BASIC_SHIFT=3.
- R4: The octant is z_i[15:13]. R3 holds in all eight octants, including angles that are exact multiples of π/4 and −π. Odd octants fold to π/4 minus the remainder, with a reflection of y that is undone on output.
- R5: Hyperbolic rotation (traj_i=0, mode_i=0) uses z_i without folding, for |θ| ≤ 1.0 rad. The shift sequence is 1, 2, 3, 4, 4, 5, 6, …. It returns x_o ≈ Kh(x·coshθ + y·sinhθ) and y_o ≈ Kh(x·sinhθ + y·coshθ), where Kh = ∏ sqrt(1−2^-2s) over that sequence. The error bound is the same as in R3.
- R6: Circular vectoring (traj_i=1, mode_i=1, x_i>0) returns x_o ≈ K·sqrt(x²+y²), y_o ≈ 0 and z_o ≈ z_i + atan2(y,x)·32768/π. The z_o error bound is 110 LSB for BASIC_SHIFT=2 and 30 LSB for BASIC_SHIFT=3.
- R7: Hyperbolic vectoring (traj_i=0, mode_i=1, |y| ≤ 0.7x) returns x_o ≈ Kh·sqrt(x²−y²) and z_o ≈ z_i + atanh(y/x)·32768/π. It uses the bounds of R6.
- R8: The iteration count N is 8 for BASIC_SHIFT=2 and 11 for BASIC_SHIFT=3. In rotation mode, done_o rises N+1 rising edges after the accepting edge. In vectoring mode, the control counter rolls over at 15 or 17, and done_o rises 17 or 19 edges after the accepting edge.
- R9: done_o is high for exactly one cycle. x_o, y_o and z_o change only on the cycle done_o rises, and hold their values after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken when ready_o is high |
| traj_i | input | 1 | 1 = circular, 0 = hyperbolic |
| mode_i | input | 1 | 0 = rotation, 1 = vectoring |
| x_i | input | W | Input x, two's complement |
| y_i | input | W | Input y, two's complement |
| z_i | input | 16 | Input angle, 8192 = π/4 |
| ready_o | output | 1 | Engine idle, can accept start_i |
| done_o | output | 1 | One-cycle pulse, results valid |
| x_o | output | W | Result x |
| y_o | output | W | Result y |
| z_o | output | 16 | Result angle (residual in rotation mode) |

## Verification
The rotation sweeps step the angle through every octant. Both exact octant boundaries and off-boundary angles are used, with a vector that has a nonzero y. A missing reflection or a wrong quarter-turn shows up as a sign flip or a swap of x and y, thousands of LSB off. The hyperbolic sweeps fail on a wrong x update sign or on a shift sequence that drops the repeated step, because the result then leaves the gain-scaled cosh/sinh envelope. Every operation is run on a BASIC_SHIFT=2 and a BASIC_SHIFT=3 instance at once, and the done latency is measured in each. An off-by-one in the iteration or rollover count therefore shows up as a latency miscompare. One run pulses start_i with different data while the engine is busy, and its result must still match the first request.

// File: rtl/cordic_pkg.sv
package cordic_pkg;
  localparam int AW = 16;      // angle width, 2**(AW-3) = pi/4
  localparam int ZW = AW + 2;  // internal angle width

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} state_e;

  function automatic int iter_count(input int bs);
    return (bs == 3) ? 11 : 8;
  endfunction

  function automatic int roll_count(input int bs);
    return (bs == 3) ? 17 : 15;
  endfunction

  // atan(2^-s) in angle units
  function automatic logic signed [ZW-1:0] circ_angle(input int s);
    case (s)
      0:  return ZW'(8192);
      1:  return ZW'(4836);
      2:  return ZW'(2555);
      3:  return ZW'(1297);
      4:  return ZW'(651);
      5:  return ZW'(326);
      6:  return ZW'(163);
      7:  return ZW'(81);
      8:  return ZW'(41);
      9:  return ZW'(20);
      10: return ZW'(10);
      default: return '0;
    endcase
  endfunction

  // atanh(2^-s) in angle units
  function automatic logic signed [ZW-1:0] hyp_angle(input int s);
    case (s)
      1:  return ZW'(5729);
      2:  return ZW'(2664);
      3:  return ZW'(1311);
      4:  return ZW'(653);
      5:  return ZW'(326);
      6:  return ZW'(163);
      7:  return ZW'(81);
      8:  return ZW'(41);
      9:  return ZW'(20);
      10: return ZW'(10);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/cordic_prep.sv
module cordic_prep
  import cordic_pkg::*;
#(
  parameter int W  = 16,
  parameter int GB = 3,
  parameter int DW = W + 2 + GB
) (
  input  logic                 traj_i,
  input  logic                 mode_i,
  input  logic signed [W-1:0]  x_i,
  input  logic signed [W-1:0]  y_i,
  input  logic [AW-1:0]        z_i,
  output logic signed [DW-1:0] x_o,
  output logic signed [DW-1:0] y_o,
  output logic signed [ZW-1:0] z_o,
  output logic [2:0]           oct_o
);
  localparam logic [AW-3:0] PI4 = (AW-2)'(1 << (AW-3));

  logic          fold;
  logic [2:0]    oct_raw;
  logic [AW-4:0] rem;
  logic [AW-3:0] psi;
  logic signed [DW-1:0] xe, ye;

  always_comb begin
    fold    = traj_i & ~mode_i;
    oct_raw = z_i[AW-1:AW-3];
    rem     = z_i[AW-4:0];
    // odd octant: rotate by pi/4 - rem on the reflected vector
    psi     = oct_raw[0] ? (PI4 - {1'b0, rem}) : {1'b0, rem};
    xe      = {{(DW-W){x_i[W-1]}}, x_i} <<< GB;
    ye      = {{(DW-W){y_i[W-1]}}, y_i} <<< GB;
    x_o     = xe;
    y_o     = (fold && oct_raw[0]) ? -ye : ye;
    z_o     = fold ? {{(ZW-AW+2){1'b0}}, psi} : {{(ZW-AW){z_i[AW-1]}}, z_i};
    oct_o   = fold ? oct_raw : 3'd0;
  end
endmodule

// File: rtl/cordic_urot.sv
module cordic_urot
  import cordic_pkg::*;
#(
  parameter int DW = 21,
  parameter int CW = 4
) (
  input  logic                 traj_i,
  input  logic                 mode_i,
  input  logic [CW-1:0]        k_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] y_i,
  input  logic signed [ZW-1:0] z_i,
  output logic signed [DW-1:0] x_o,
  output logic signed [DW-1:0] y_o,
  output logic signed [ZW-1:0] z_o
);
  localparam int NS = 2 ** CW;

  logic signed [DW-1:0] shx [NS];
  logic signed [DW-1:0] shy [NS];

  // fixed-amount shift copies; the iteration index only selects one
  for (genvar s = 0; s < NS; s++) begin : g_sh
    assign shx[s] = x_i >>> s;
    assign shy[s] = y_i >>> s;
  end

  logic [CW-1:0]        sh;
  logic                 pos;
  logic signed [DW-1:0] tx, ty;
  logic signed [ZW-1:0] ang;

  always_comb begin
    // hyperbolic: 1,2,3,4,4,5,...
    sh  = traj_i ? k_i : ((k_i < CW'(4)) ? k_i + CW'(1) : k_i);
    ang = traj_i ? circ_angle(int'(sh)) : hyp_angle(int'(sh));
    pos = mode_i ? y_i[DW-1] : ~z_i[ZW-1];
    tx  = shy[sh];
    ty  = shx[sh];
    if (traj_i) x_o = pos ? x_i - tx : x_i + tx;
    else        x_o = pos ? x_i + tx : x_i - tx;
    y_o = pos ? y_i + ty : y_i - ty;
    z_o = pos ? z_i - ang : z_i + ang;
  end
endmodule

// File: rtl/cordic_post.sv
module cordic_post #(
  parameter int W  = 16,
  parameter int GB = 3,
  parameter int DW = W + 2 + GB
) (
  input  logic [2:0]           oct_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] y_i,
  output logic signed [W-1:0]  x_o,
  output logic signed [W-1:0]  y_o
);
  localparam logic signed [DW-1:0] VMAX = DW'((1 << (W-1)) - 1);
  localparam logic signed [DW-1:0] VMIN = -VMAX - DW'(1);

  logic signed [DW-1:0] yr, xa, ya, xs, ys;
  logic [2:0] qs;
  logic unused_frac;

  always_comb begin
    yr = oct_i[0] ? -y_i : y_i;
    qs = oct_i + 3'd1;  // quarter turns = (oct+1)>>1
    case (qs[2:1])
      2'd0: begin xa = x_i;  ya = yr;   end
      2'd1: begin xa = -yr;  ya = x_i;  end
      2'd2: begin xa = -x_i; ya = -yr;  end
      default: begin xa = yr; ya = -x_i; end
    endcase
    xs  = xa >>> GB;
    ys  = ya >>> GB;
    x_o = (xs > VMAX) ? VMAX[W-1:0] : (xs < VMIN) ? VMIN[W-1:0] : xs[W-1:0];
    y_o = (ys > VMAX) ? VMAX[W-1:0] : (ys < VMIN) ? VMIN[W-1:0] : ys[W-1:0];
  end

  assign unused_frac = ^{xa[GB-1:0], ya[GB-1:0]};
endmodule

// File: rtl/cordic_engine.sv
module cordic_engine
  import cordic_pkg::*;
#(
  parameter int W           = 16,
  parameter int BASIC_SHIFT = 2,
  parameter int GB          = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                traj_i,
  input  logic                mode_i,
  input  logic signed [W-1:0] x_i,
  input  logic signed [W-1:0] y_i,
  input  logic [AW-1:0]       z_i,
  output logic                ready_o,
  output logic                done_o,
  output logic signed [W-1:0] x_o,
  output logic signed [W-1:0] y_o,
  output logic [AW-1:0]       z_o
);
  localparam int N    = iter_count(BASIC_SHIFT);
  localparam int ROLL = roll_count(BASIC_SHIFT);
  localparam int CW   = $clog2(ROLL + 1);
  localparam int DW   = W + 2 + GB;
  localparam logic signed [ZW-1:0] PI4Z = ZW'(1 << (AW-3));

  state_e               state_q;
  logic [CW-1:0]        cnt_q, k_eff, last;
  logic signed [DW-1:0] x_q, y_q, pre_x, pre_y, nx, ny;
  logic signed [ZW-1:0] z_q, pre_z, nz;
  logic signed [W-1:0]  px, py;
  logic [2:0]           oct_q, pre_oct;
  logic                 traj_q, mode_q, done_q;

  cordic_prep #(.W(W), .GB(GB), .DW(DW)) u_prep (
    .traj_i(traj_i), .mode_i(mode_i), .x_i(x_i), .y_i(y_i), .z_i(z_i),
    .x_o(pre_x), .y_o(pre_y), .z_o(pre_z), .oct_o(pre_oct)
  );

  always_comb begin
    k_eff = (cnt_q < CW'(N)) ? cnt_q : CW'(N - 1);
    last  = mode_q ? CW'(ROLL) : CW'(N - 1);
  end

  cordic_urot #(.DW(DW), .CW(CW)) u_rot (
    .traj_i(traj_q), .mode_i(mode_q), .k_i(k_eff),
    .x_i(x_q), .y_i(y_q), .z_i(z_q),
    .x_o(nx), .y_o(ny), .z_o(nz)
  );

  cordic_post #(.W(W), .GB(GB), .DW(DW)) u_post (
    .oct_i(oct_q), .x_i(x_q), .y_i(y_q), .x_o(px), .y_o(py)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      x_q     <= '0;
      y_q     <= '0;
      z_q     <= '0;
      oct_q   <= '0;
      traj_q  <= 1'b0;
      mode_q  <= 1'b0;
      done_q  <= 1'b0;
      x_o     <= '0;
      y_o     <= '0;
      z_o     <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          x_q     <= pre_x;
          y_q     <= pre_y;
          z_q     <= pre_z;
          oct_q   <= pre_oct;
          traj_q  <= traj_i;
          mode_q  <= mode_i;
          cnt_q   <= '0;
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (cnt_q < CW'(N)) begin
            x_q <= nx;
            y_q <= ny;
            z_q <= nz;
          end
          if (cnt_q == last) begin
            cnt_q   <= '0;
            state_q <= ST_DONE;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: begin
          x_o     <= px;
          y_o     <= py;
          z_o     <= z_q[AW-1:0];
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign ready_o = (state_q == ST_IDLE);
  assign done_o  = done_q;

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_hold_results: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(x_o) && $stable(y_o) && $stable(z_o)));

  a_r2_op_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> ($stable(traj_q) && $stable(mode_q) && $stable(oct_q)));

  a_r2_ready_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);

  a_r8_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |-> (cnt_q <= last));

  a_r4_fold_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ready_o && traj_i && !mode_i) |-> (!pre_z[ZW-1] && pre_z <= PI4Z));

  a_r5_no_fold_hyp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ready_o && !traj_i) |=> (oct_q == 3'd0));
endmodule

// File: tb/tb_cordic_engine.sv
`timescale 1ns/1ps
module tb_cordic_engine;
  localparam real PI = 3.14159265358979;
  localparam real SC = 32768.0 / PI;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, traj = 1'b0, mode = 1'b0;
  logic signed [15:0] xi = '0, yi = '0;
  logic [15:0] zi = '0;
  logic rdy2, dn2, rdy3, dn3;
  logic signed [15:0] xo2, yo2, xo3, yo3;
  logic [15:0] zo2, zo3;

  cordic_engine #(.W(16), .BASIC_SHIFT(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .traj_i(traj), .mode_i(mode),
    .x_i(xi), .y_i(yi), .z_i(zi), .ready_o(rdy2), .done_o(dn2),
    .x_o(xo2), .y_o(yo2), .z_o(zo2)
  );

  cordic_engine #(.W(16), .BASIC_SHIFT(3)) dut_b3 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .traj_i(traj), .mode_i(mode),
    .x_i(xi), .y_i(yi), .z_i(zi), .ready_o(rdy3), .done_o(dn3),
    .x_o(xo3), .y_o(yo3), .z_o(zo3)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(input string req, input bit ok, input string what,
                       input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0.2f expected=%0.2f", req, what, act, exp);
    end
  endtask

  task automatic near(input string req, input string what, input real act,
                      input real exp, input real tol);
    check(req, (act - exp <= tol) && (exp - act <= tol), what, act, exp);
  endtask

  function automatic real kc(input int n);
    real p = 1.0;
    for (int k = 0; k < n; k++) p = p * $sqrt(1.0 + 2.0 ** (-2.0 * k));
    return p;
  endfunction

  function automatic real kh(input int n);
    real p = 1.0;
    for (int k = 0; k < n; k++) begin
      int s = (k < 4) ? k + 1 : k;
      p = p * $sqrt(1.0 - 2.0 ** (-2.0 * s));
    end
    return p;
  endfunction

  task automatic expect_op(input bit tr, input bit md, input int n, input real x,
                           input real y, input int zc, output real ex,
                           output real ey, output real ez);
    real th = real'(zc) * PI / 32768.0;
    ez = 0.0;
    if (!md && tr) begin
      ex = kc(n) * (x * $cos(th) - y * $sin(th));
      ey = kc(n) * (x * $sin(th) + y * $cos(th));
    end else if (!md) begin
      ex = kh(n) * (x * $cosh(th) + y * $sinh(th));
      ey = kh(n) * (x * $sinh(th) + y * $cosh(th));
    end else if (tr) begin
      ex = kc(n) * $sqrt(x * x + y * y);
      ey = 0.0;
      ez = real'(zc) + $atan2(y, x) * SC;
    end else begin
      ex = kh(n) * $sqrt(x * x - y * y);
      ey = 0.0;
      ez = real'(zc) + $atanh(y / x) * SC;
    end
  endtask

  task automatic do_op(input string req, input bit tr, input bit md, input int x,
                       input int y, input int zc, input bit poke);
    real ex2, ey2, ez2, ex3, ey3, ez3, tol2, tol3, zt2, zt3;
    int lat2, lat3, sx2, sy2, sz2, sx3, sy3, sz3, c;
    bit seen2 = 0, seen3 = 0;
    int c2 = -1, c3 = -1;
    expect_op(tr, md, 8, real'(x), real'(y), zc, ex2, ey2, ez2);
    expect_op(tr, md, 11, real'(x), real'(y), zc, ex3, ey3, ez3);
    tol2 = 72.0; tol3 = 24.0; zt2 = 110.0; zt3 = 30.0;
    lat2 = md ? 17 : 9;
    lat3 = md ? 19 : 12;
    @(negedge clk);
    check("R2", rdy2 && rdy3, "ready before start", real'(rdy2 + rdy3), 2.0);
    traj = tr; mode = md; xi = 16'(x); yi = 16'(y); zi = 16'(zc); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2", !rdy2 && !rdy3, "ready after accept", real'(rdy2 + rdy3), 0.0);
    c = 0;
    while (c < 26) begin
      if (poke && c == 2) begin
        start = 1'b1; xi = -xi; zi = zi + 16'd4096; traj = ~traj;
      end
      if (poke && c == 3) start = 1'b0;
      if (seen2 && c == c2 + 1) begin
        check("R9", !dn2, "done width b2", real'(dn2), 0.0);
        check("R9", int'(xo2) == sx2 && int'(yo2) == sy2 && int'($signed(zo2)) == sz2,
              "hold b2", real'(xo2), real'(sx2));
      end
      if (seen3 && c == c3 + 1) begin
        check("R9", !dn3, "done width b3", real'(dn3), 0.0);
        check("R9", int'(xo3) == sx3 && int'(yo3) == sy3 && int'($signed(zo3)) == sz3,
              "hold b3", real'(xo3), real'(sy3));
      end
      if (dn2 && !seen2) begin
        seen2 = 1; c2 = c; sx2 = int'(xo2); sy2 = int'(yo2); sz2 = int'($signed(zo2));
        check("R8", c == lat2, "latency b2", real'(c), real'(lat2));
        check("R2", rdy2, "ready at done b2", real'(rdy2), 1.0);
        near(req, "x b2", real'(sx2), ex2, tol2);
        near(req, "y b2", real'(sy2), ey2, tol2);
        if (md) near(req, "z b2", real'(sz2), ez2, zt2);
      end
      if (dn3 && !seen3) begin
        seen3 = 1; c3 = c; sx3 = int'(xo3); sy3 = int'(yo3); sz3 = int'($signed(zo3));
        check("R8", c == lat3, "latency b3", real'(c), real'(lat3));
        near(req, "x b3", real'(sx3), ex3, tol3);
        near(req, "y b3", real'(sy3), ey3, tol3);
        if (md) near(req, "z b3", real'(sz3), ez3, zt3);
      end
      @(negedge clk);
      c++;
    end
    check("R8", seen2 && seen3, "done seen", real'(seen2 + seen3), 2.0);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #12;
    // R1: reset state
    check("R1", rdy2 && rdy3 && !dn2 && !dn3, "ready/done in reset",
          real'(rdy2 + dn2), 1.0);
    check("R1", xo2 == 0 && yo2 == 0 && zo2 == 0 && xo3 == 0 && yo3 == 0 && zo3 == 0,
          "outputs in reset", real'(xo2), 0.0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", rdy2 && !dn2 && xo2 == 0, "after release", real'(rdy2), 1.0);

    // R3: full-turn sweep, unit x vector, includes multiples of pi/4
    for (int k = 0; k < 64; k++) do_op("R3", 1'b1, 1'b0, 4000, 0, k * 1024, 1'b0);
    // R4: all octants, off-boundary, vector with y
    for (int k = 0; k < 32; k++) do_op("R4", 1'b1, 1'b0, 2500, -3000, k * 2048 + 1500, 1'b0);
    do_op("R4", 1'b1, 1'b0, 3000, 2000, -32768, 1'b0);
    // R5: hyperbolic rotation
    for (int i = -10; i <= 10; i++) begin
      real th = 0.1 * i;
      int zc = $rtoi(th * SC + ((th >= 0.0) ? 0.5 : -0.5));
      do_op("R5", 1'b0, 1'b0, 3000, (i % 2 != 0) ? 500 : -400, zc, 1'b0);
    end
    // R6: circular vectoring
    for (int i = 0; i < 24; i++) begin
      real a = (-80.0 + 7.0 * i) * PI / 180.0;
      do_op("R6", 1'b1, 1'b1, $rtoi(4000.0 * $cos(a)), $rtoi(4000.0 * $sin(a)),
            (i == 5) ? 1000 : 0, 1'b0);
    end
    // R7: hyperbolic vectoring
    for (int i = 0; i < 15; i++) begin
      real r = -0.7 + 0.1 * i;
      do_op("R7", 1'b0, 1'b1, 4000, $rtoi(r * 4000.0), (i == 3) ? -500 : 0, 1'b0);
    end
    // R2: start pulse with other data while busy
    do_op("R2", 1'b1, 1'b0, 4000, 1000, 5000, 1'b1);
    do_op("R2", 1'b1, 1'b1, 3000, 1500, 0, 1'b1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule